// File: doc/BRIEF.md
# Split-Section Ripple Counter

This block is a four-bit binary counter cut into two sections that count on their own. The head section is a single toggle stage that divides its count input by two. The tail section is a chain of three toggle stages that divides its own count input by eight. Each stage after the first in the tail is advanced by the high-to-low transition of the stage before it. Every count input acts on its high-to-low transition. The head output is not wired into the tail. A wrapper or the surrounding logic can tie `cnt_q[0]` to `cnt_in_tail` and count on `cnt_in_head` to get one four-bit counter. Without that tie the tail works as a three-bit counter and the head is a separate divide-by-two.

The block sits in a synchronous chip, so the count inputs are levels sampled on `clk`. Each section input has its own edge watcher. This is a two-state machine: it moves from `LVL_LOW` to `LVL_HIGH` when the input is sampled high. It moves back from `LVL_HIGH` to `LVL_LOW`, and emits a one-cycle advance, when the input is sampled low. Each stage is a two-state machine too: on an advance it moves from `TGL_LOW` to `TGL_HIGH` or from `TGL_HIGH` to `TGL_LOW`, and without an advance it stays in its state. The ripple costs one clock per stage. Outputs are valid once the ripple has settled, at most three clocks after the edge that started it.

A clear request needs both `clr_a` and `clr_b` high. It empties every stage at once, without waiting for a clock edge, and it overrides both count inputs. The active-low `rst_n` is the system reset.

Top module: `split_ripple_counter`

## Requirements
- R1: `cnt_q[0]` toggles at the first rising `clk` edge at which `cnt_in_head` is sampled low after being sampled high, and it holds its value at every other edge.
- R2: `cnt_q[1]` toggles on each high-to-low transition of `cnt_in_tail`, sampled as in R1. `cnt_in_head` never changes `cnt_q[3:1]`, and `cnt_in_tail` never changes `cnt_q[0]`.
- R3: `cnt_q[2]` toggles at the clock edge after the one at which `cnt_q[1]` fell. `cnt_q[3]` toggles at the clock edge after the one at which `cnt_q[2]` fell. So `cnt_q[3:1]` counts up in binary with `cnt_q[1]` as its least significant bit.
- R4: The tail wraps from 7 (`cnt_q[3:1]` = 111) to 0 on the next count.
- R5: With `cnt_in_tail` driven from `cnt_q[0]` and counts applied to `cnt_in_head`, `cnt_q[3:0]` counts up in binary from 0 to 15 and wraps to 0.
- R6: In the chained mode of R5, 32 counts produce 16, 8, 4 and 2 rising edges on `cnt_q[0]` to `cnt_q[3]`, that is division by 2, 4, 8 and 16. With 16 counts on `cnt_in_tail` alone, `cnt_q[1]` to `cnt_q[3]` give 8, 4 and 2 rising edges.
- R7: While `clr_a` and `clr_b` are both high, `cnt_q` is 0, and it becomes 0 without waiting for a clock edge.
- R8: `clr_a` or `clr_b` high on its own has no effect: counting goes on as if neither were high.
- R9: Count-input transitions made while the clear request is held are ignored. After the request is released, the first high-to-low transition on each input counts: one pulse on each input then gives `cnt_q` = 0011.
- R10: While `rst_n` is low, `cnt_q` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the count inputs and the stage registers |
| rst_n | input | 1 | System reset, active low, asynchronous |
| cnt_in_head | input | 1 | Count input of the single-stage head section; acts on its falling transition |
| cnt_in_tail | input | 1 | Count input of the three-stage tail section; acts on its falling transition |
| clr_a | input | 1 | First clear request leg, active high |
| clr_b | input | 1 | Second clear request leg, active high; a clear happens only with both legs high |
| cnt_q | output | 4 | Stage outputs; bit 0 is the head stage, bits 3:1 are the tail chain |

## Verification
The hardest case to reach is a clear request that lands in the middle of a ripple, or one that comes while the count inputs are moving. The stages must drop straight to zero there, and the edge watchers must not hand over a stale transition once the request goes away. The stimulus holds both clear legs high while it pulses both count inputs. It then releases the legs and checks that one pulse on each input gives exactly 0011. A random phase also fires full clears and single-leg clears between mixed head, tail and simultaneous pulses, so clears arrive at varied points in a ripple.

// File: rtl/src_pkg.sv
package src_pkg;

    // Last sampled level of a count input (edge watcher)
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    // Value held by one divide-by-two stage
    typedef enum logic {
        TGL_LOW  = 1'b0,
        TGL_HIGH = 1'b1
    } tgl_state_e;

endpackage

// File: rtl/src_fall_detect.sv
module src_fall_detect
    import src_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic lvl_i,
    output logic fall_o
);

    lvl_state_e state_q;
    lvl_state_e state_d;

    // Next-state logic: follow the sampled level
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_LOW:  if (lvl_i)  state_d = LVL_HIGH;
            LVL_HIGH: if (!lvl_i) state_d = LVL_LOW;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= LVL_LOW;
        else         state_q <= state_d;
    end

    // Output logic: a high-to-low step gives a one-cycle advance
    always_comb begin
        fall_o = 1'b0;
        unique case (state_q)
            LVL_LOW:  fall_o = 1'b0;
            LVL_HIGH: fall_o = !lvl_i;
        endcase
    end

    // R1
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!arst_n)
        fall_o |=> !fall_o);

endmodule

// File: rtl/src_toggle_stage.sv
module src_toggle_stage
    import src_pkg::*;
(
    input  logic clk,
    input  logic arst_n,
    input  logic adv_i,
    output logic q_o
);

    tgl_state_e state_q;
    tgl_state_e state_d;

    // Next-state logic: flip on advance, hold otherwise
    always_comb begin
        state_d = state_q;
        if (adv_i) begin
            unique case (state_q)
                TGL_LOW:  state_d = TGL_HIGH;
                TGL_HIGH: state_d = TGL_LOW;
            endcase
        end
    end

    // State register, cleared asynchronously
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) state_q <= TGL_LOW;
        else         state_q <= state_d;
    end

    // Output logic
    always_comb begin
        q_o = 1'b0;
        unique case (state_q)
            TGL_LOW:  q_o = 1'b0;
            TGL_HIGH: q_o = 1'b1;
        endcase
    end

    // R1
    toggle_on_adv_chk: assert property (@(posedge clk) disable iff (!arst_n)
        adv_i |=> (q_o != $past(q_o)));

    // R1
    hold_no_adv_chk: assert property (@(posedge clk) disable iff (!arst_n)
        !adv_i |=> $stable(q_o));

endmodule

// File: rtl/src_ripple_section.sv
module src_ripple_section #(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              in_rst_n,
    input  logic              chain_rst_n,
    input  logic              tick_i,
    output logic [STAGES-1:0] q_o
);

    logic [STAGES-1:0] src;
    logic [STAGES-1:0] adv;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_entry
            // The input watcher keeps tracking through a clear so that
            // transitions seen during the clear are consumed
            assign src[i] = tick_i;
            src_fall_detect u_edge (
                .clk    (clk),
                .arst_n (in_rst_n),
                .lvl_i  (src[i]),
                .fall_o (adv[i])
            );
        end else begin : g_link
            assign src[i] = q_o[i-1];
            src_fall_detect u_edge (
                .clk    (clk),
                .arst_n (chain_rst_n),
                .lvl_i  (src[i]),
                .fall_o (adv[i])
            );

            // R3
            ripple_order_chk: assert property (@(posedge clk) disable iff (!chain_rst_n)
                $fell(q_o[i-1]) |=> (q_o[i] != $past(q_o[i])));
        end

        src_toggle_stage u_bit (
            .clk    (clk),
            .arst_n (chain_rst_n),
            .adv_i  (adv[i]),
            .q_o    (q_o[i])
        );
    end

endmodule

// File: rtl/split_ripple_counter.sv
module split_ripple_counter #(
    parameter int HEAD_STAGES = 1,
    parameter int TAIL_STAGES = 3
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cnt_in_head,
    input  logic                               cnt_in_tail,
    input  logic                               clr_a,
    input  logic                               clr_b,
    output logic [HEAD_STAGES+TAIL_STAGES-1:0] cnt_q
);

    localparam int CNT_W = HEAD_STAGES + TAIL_STAGES;

    logic                   clr_req;
    logic                   chain_rst_n;
    logic [HEAD_STAGES-1:0] head_q;
    logic [TAIL_STAGES-1:0] tail_q;

    // Both legs must be high; the request overrides every stage
    assign clr_req     = clr_a & clr_b;
    assign chain_rst_n = rst_n & ~clr_req;

    src_ripple_section #(.STAGES(HEAD_STAGES)) u_head (
        .clk         (clk),
        .in_rst_n    (rst_n),
        .chain_rst_n (chain_rst_n),
        .tick_i      (cnt_in_head),
        .q_o         (head_q)
    );

    src_ripple_section #(.STAGES(TAIL_STAGES)) u_tail (
        .clk         (clk),
        .in_rst_n    (rst_n),
        .chain_rst_n (chain_rst_n),
        .tick_i      (cnt_in_tail),
        .q_o         (tail_q)
    );

    assign cnt_q = {tail_q, head_q};

    // R7 and R10
    clear_zero_chk: assert property (@(posedge clk)
        !chain_rst_n |-> (cnt_q == CNT_W'(0)));

endmodule

// File: tb/tb_split_ripple_counter.sv
module tb_split_ripple_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick0 = 1'b0;
    logic       tick1_drv = 1'b0;
    logic       chain = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       tick1;
    logic [3:0] q;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    bit  mon_en = 1'b0;
    int  rises [4];
    logic [3:0] q_prev = 4'b0;

    // Reference state
    logic hd = 1'b0;
    int   tl = 0;
    int   ch = 0;

    always #4 clk = ~clk;

    assign tick1 = chain ? q[0] : tick1_drv;

    split_ripple_counter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_in_head (tick0),
        .cnt_in_tail (tick1),
        .clr_a       (clr_a),
        .clr_b       (clr_b),
        .cnt_q       (q)
    );

    // Rising-edge counter per output bit, sampled away from the active edge
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            if (!mon_en)                   rises[k] = 0;
            else if (q[k] && !q_prev[k])   rises[k] = rises[k] + 1;
        end
        q_prev = q;
    end

    function automatic logic [3:0] exp_split(input logic h, input int t);
        return {3'(t % 8), h};
    endfunction

    function automatic logic [3:0] exp_chain(input int n);
        return 4'(n % 16);
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic h, input logic t);
        @(negedge clk);
        if (h) tick0 = 1'b1;
        if (t) tick1_drv = 1'b1;
        @(negedge clk);
        tick0 = 1'b0;
        tick1_drv = 1'b0;
        idle(2);
    endtask

    task automatic full_clear();
        @(negedge clk);
        clr_a = 1'b1;
        clr_b = 1'b1;
        idle(2);
        clr_a = 1'b0;
        clr_b = 1'b0;
        idle(2);
        hd = 1'b0; tl = 0; ch = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20411);

        // R10: reset state
        idle(3);
        check("R10", q, 0, "during reset");
        rst_n = 1'b1;
        idle(2);
        check("R10", q, 0, "after reset");

        // R1: head toggles per falling edge
        pulse(1, 0); hd = ~hd; idle(3);
        check("R1", q, exp_split(hd, tl), "first head pulse");
        pulse(1, 0); hd = ~hd; idle(3);
        check("R1", q, exp_split(hd, tl), "second head pulse");

        // R2: tail counts on its own input, head untouched
        for (int i = 0; i < 3; i++) begin pulse(0, 1); tl++; end
        idle(3);
        check("R2", q, exp_split(hd, tl), "tail at 3, head idle");

        // R3: ripple 3 -> 4, one stage per clock
        @(negedge clk); tick1_drv = 1'b1;
        @(negedge clk); tick1_drv = 1'b0;
        @(negedge clk); check("R3", q[3:1], 3'b010, "ripple step 1");
        @(negedge clk); check("R3", q[3:1], 3'b000, "ripple step 2");
        @(negedge clk); check("R3", q[3:1], 3'b100, "ripple step 3");
        tl++;

        pulse(1, 0); hd = ~hd; idle(3);
        check("R2", q, exp_split(hd, tl), "head pulse leaves tail");

        // R4: tail wrap
        for (int i = 0; i < 3; i++) begin pulse(0, 1); tl++; end
        idle(3);
        check("R4", q, 4'b1111, "tail at 7");
        pulse(0, 1); tl++; idle(3);
        check("R4", q, 4'b0001, "tail wrapped to 0");

        // R8: one leg alone does nothing
        clr_a = 1'b1;
        pulse(0, 1); tl++; idle(3);
        check("R8", q, exp_split(hd, tl), "clr_a alone");
        clr_a = 1'b0; clr_b = 1'b1;
        pulse(1, 0); hd = ~hd; idle(3);
        check("R8", q, exp_split(hd, tl), "clr_b alone");
        clr_b = 1'b0;

        // R7: immediate clear
        @(negedge clk);
        clr_a = 1'b1; clr_b = 1'b1;
        #1;
        check("R7", q, 0, "zero before next clock edge");
        // R9: pulses during clear ignored
        pulse(1, 1); pulse(1, 1);
        check("R9", q, 0, "pulses while clear held");
        @(negedge clk);
        clr_a = 1'b0; clr_b = 1'b0;
        idle(2);
        check("R9", q, 0, "after release");
        pulse(1, 1); idle(3);
        check("R9", q, 4'b0011, "first pulses after release");
        hd = 1'b1; tl = 1;

        // Random mix in split mode
        for (int it = 0; it < 300; it++) begin
            int r;
            r = int'($urandom % 8);
            if (r <= 2) begin
                pulse(1, 0); hd = ~hd;
            end else if (r <= 5) begin
                pulse(0, 1); tl++;
            end else if (r == 6) begin
                pulse(1, 1); hd = ~hd; tl++;
            end else begin
                if ($urandom % 2 == 0) clr_a = 1'b1; else clr_b = 1'b1;
                pulse(1, 1); hd = ~hd; tl++;
                clr_a = 1'b0; clr_b = 1'b0;
            end
            if (it % 10 == 9) begin
                idle(3);
                check("R2", q, exp_split(hd, tl), "random split mode");
            end
            if (it % 50 == 25) begin
                @(negedge clk);
                clr_a = 1'b1; clr_b = 1'b1;
                idle(1);
                check("R7", q, 0, "random full clear");
                clr_a = 1'b0; clr_b = 1'b0;
                idle(2);
                hd = 1'b0; tl = 0;
            end
        end

        // Chained mode
        full_clear();
        chain = 1'b1;
        idle(2);
        for (int i = 0; i < 15; i++) begin pulse(1, 0); ch++; end
        idle(4);
        check("R5", q, 15, "chained count at 15");
        pulse(1, 0); ch++; idle(4);
        check("R5", q, 0, "chained wrap to 0");

        // R6: division ratios in chained mode
        @(negedge clk); mon_en = 1'b1;
        for (int i = 0; i < 32; i++) begin pulse(1, 0); ch++; end
        idle(5);
        for (int k = 0; k < 4; k++)
            check("R6", rises[k], 16 >> k, $sformatf("chained rises on bit %0d", k));
        mon_en = 1'b0;
        check("R5", q, exp_chain(ch), "chained after 32 counts");

        for (int it = 0; it < 40; it++) begin
            int n;
            n = 1 + int'($urandom % 20);
            for (int i = 0; i < n; i++) begin pulse(1, 0); ch++; end
            idle(4);
            check("R5", q, exp_chain(ch), "random chained run");
        end

        // R6: division ratios in tail-only mode
        full_clear();
        chain = 1'b0;
        idle(2);
        @(negedge clk); mon_en = 1'b1;
        for (int i = 0; i < 16; i++) pulse(0, 1);
        idle(5);
        check("R2", rises[0], 0, "head idle during tail counting");
        for (int k = 1; k < 4; k++)
            check("R6", rises[k], 8 >> (k - 1), $sformatf("tail rises on bit %0d", k));
        mon_en = 1'b0;
        check("R4", q, 0, "tail back to 0 after 16 counts");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule